// File: doc/BRIEF.md
# Two-Bank SDRAM Write Burst Engine with Precharge Cut-Off

This block is the write side of a small synchronous DRAM model with two banks. It takes decoded commands from a controller, one per clock. Each command carries a bank select, and ACTIVE also carries a row. A WRITE to an open bank stores four bytes, one per clock. The first byte is taken on the WRITE clock itself, and each later byte goes to the next column within an aligned group of four columns. The row is the one most recently opened in that bank.

A PRECHARGE to the bank that holds the burst stops the burst at once, and the byte presented on that clock is dropped. A PRECHARGE to the other bank only closes that bank, and the burst goes on. A PRECHARGE that arrives too soon after the final byte is reported as a write-recovery violation, separately from a deliberate cut-off. Misuse of WRITE raises a sticky error flag. A CAS-latency setting is accepted but has no effect on write timing. The storage is a register array with a combinational peek port, so the whole contents can be compared against a model.

Top module: `sdwb_top`

## Requirements
- R1: Commands are encoded on cmd_i as 0 = NOP, 1 = ACTIVE, 2 = WRITE, 3 = PRECHARGE. A WRITE to an open bank stores din_i on the WRITE clock and on each of the next three clocks. The columns are {col[3:2], col[1:0]+k} for k = 0..3, so they wrap inside the aligned group of four. The row is the one given by the bank's last ACTIVE. burst_busy_o is high for the three clocks that follow the WRITE edge.
- R2: When dqm_i is 1 on a beat clock, the byte on that clock is not stored, and the burst still advances to the next column.
- R3: A PRECHARGE to the bursting bank during beats 1 to 3 stores nothing on that clock, whatever dqm_i is. burst_busy_o is low after that edge, and the bank closes.
- R4: A PRECHARGE to the other bank during a burst clears only that bank's bank_open_o bit. The burst completes all four beats.
- R5: The value of cas_lat3_i does not change any stored byte, any timing, or any output.
- R6: A WRITE to a closed bank stores nothing, starts no burst, and sets err_o. err_o then stays high until reset.
- R7: A WRITE to an open bank while a burst is running sets err_o. It restarts the burst at its own bank and column, and the old burst stores nothing further.
- R8: A PRECHARGE to the bank whose burst completed its final beat on the previous clock drives rec_viol_o high for exactly the one clock after that PRECHARGE edge. A PRECHARGE issued one clock later raises no pulse. The four beats stay stored in both cases.
- R9: During and after reset, all banks are closed, burst_busy_o, err_o and rec_viol_o are 0, and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 2 | Decoded command (0 NOP, 1 ACTIVE, 2 WRITE, 3 PRECHARGE) |
| bank_i | input | 1 | Bank select for the command |
| row_i | input | 2 | Row for ACTIVE |
| col_i | input | 4 | Start column for WRITE |
| din_i | input | 8 | Write data byte |
| dqm_i | input | 1 | Data mask; 1 blocks the byte on this clock |
| cas_lat3_i | input | 1 | CAS latency select (0 = 2, 1 = 3); no effect on writes |
| rd_bank_i | input | 1 | Peek port bank |
| rd_row_i | input | 2 | Peek port row |
| rd_col_i | input | 4 | Peek port column |
| rd_data_o | output | 8 | Peek port data (combinational) |
| bank_open_o | output | 2 | One bit per bank, 1 while the bank is open |
| burst_busy_o | output | 1 | A burst has beats still to take |
| err_o | output | 1 | Sticky WRITE misuse flag |
| rec_viol_o | output | 1 | One-clock write-recovery violation pulse |

## Verification
The assertions assume that the controller never issues ACTIVE to the bank holding a running burst, because the row used by the remaining beats would then change under them. The bench's directed sequences respect this. Its pseudo-random phase turns any such ACTIVE into a NOP before driving it. All other command orders, including WRITE to a closed bank, WRITE during a burst and PRECHARGE on any clock, are driven freely. Each is compared against the reference model on every clock.

// File: rtl/sdwb_pkg.sv
// sdwb_pkg: shared command encoding and burst constants for the write
// burst engine. Assumes a single decoded command per clock.
package sdwb_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);
endpackage

// File: rtl/sdwb_bank_track.sv
// sdwb_bank_track: keeps the open flag and the active row of every bank.
// Assumes ACTIVE and PRECHARGE are mutually exclusive on a clock.
module sdwb_bank_track #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    parameter int ROW_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              act_en,
    input  logic                              pre_en,
    input  logic [BANK_W-1:0]                 bank,
    input  logic [ROW_W-1:0]                  row,
    output logic [NUM_BANKS-1:0]              open_o,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]   row_tab_o
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (bank == BANK_W'(g));

        // Open or close this bank and latch its row on ACTIVE.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_o[g]    <= 1'b0;
                row_tab_o[g] <= '0;
            end else if (hit && act_en) begin
                open_o[g]    <= 1'b1;
                row_tab_o[g] <= row;
            end else if (hit && pre_en) begin
                open_o[g]    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdwb_burst_ctrl.sv
// sdwb_burst_ctrl: sequences the four beats of a write burst, handles the
// same-bank precharge cut-off and WRITE restart, and raises the misuse
// error. Assumes bank_open reflects the state before this clock's command.
module sdwb_burst_ctrl
    import sdwb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    parameter int COL_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_e                  cmd,
    input  logic [BANK_W-1:0]     bank,
    input  logic [COL_W-1:0]      col,
    input  logic                  dqm,
    input  logic [NUM_BANKS-1:0]  bank_open,
    output logic                  busy_o,
    output logic [BANK_W-1:0]     burst_bank_o,
    output logic [BEAT_W-1:0]     beat_idx_o,
    output logic                  wr_en_o,
    output logic [BANK_W-1:0]     wr_bank_o,
    output logic [COL_W-1:0]      wr_col_o,
    output logic                  last_beat_o,
    output logic                  err_o
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);

    logic [COL_W-1:0] base_col_q;
    logic [COL_W-1:0] beat_col;
    logic             wr_cmd;
    logic             wr_ok;
    logic             same_pre;
    logic             cont;

    // Classify this clock's command against the burst state.
    always_comb begin
        wr_cmd   = (cmd == CMD_WR);
        wr_ok    = wr_cmd && bank_open[bank];
        same_pre = busy_o && (cmd == CMD_PRE) && (bank == burst_bank_o);
        cont     = busy_o && !same_pre && !wr_ok;
    end

    // Column of the current beat, wrapping inside the aligned group.
    always_comb begin
        beat_col = base_col_q;
        beat_col[BEAT_W-1:0] = base_col_q[BEAT_W-1:0] + beat_idx_o;
    end

    // Write strobe and address toward the array.
    always_comb begin
        wr_en_o     = (wr_ok || cont) && !dqm;
        wr_bank_o   = wr_ok ? bank : burst_bank_o;
        wr_col_o    = wr_ok ? col : beat_col;
        last_beat_o = cont && (beat_idx_o == LAST_IDX);
    end

    // Burst state: start, advance, finish or cut off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o       <= 1'b0;
            beat_idx_o   <= '0;
            base_col_q   <= '0;
            burst_bank_o <= '0;
        end else if (wr_ok) begin
            busy_o       <= 1'b1;
            beat_idx_o   <= BEAT_W'(1);
            base_col_q   <= col;
            burst_bank_o <= bank;
        end else if (cont) begin
            busy_o       <= (beat_idx_o != LAST_IDX);
            beat_idx_o   <= beat_idx_o + BEAT_W'(1);
        end else if (same_pre) begin
            busy_o       <= 1'b0;
            beat_idx_o   <= '0;
        end
    end

    // Sticky misuse flag: WRITE to a closed bank or during a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (wr_cmd && (!bank_open[bank] || busy_o)) begin
            err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sdwb_recovery.sv
// sdwb_recovery: flags a same-bank PRECHARGE on the clock right after a
// burst's final beat. Assumes last_beat marks a beat that was taken.
module sdwb_recovery
    import sdwb_pkg::*;
#(
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_beat,
    input  logic [BANK_W-1:0] burst_bank,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    output logic              viol_o
);
    logic              pend_q;
    logic [BANK_W-1:0] pend_bank_q;

    // Remember a just-finished burst and check the next command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_bank_q <= '0;
            viol_o      <= 1'b0;
        end else begin
            viol_o      <= pend_q && (cmd == CMD_PRE) && (bank == pend_bank_q);
            pend_q      <= last_beat;
            pend_bank_q <= burst_bank;
        end
    end
endmodule

// File: rtl/sdwb_array.sv
// sdwb_array: register store of NUM_BANKS x rows x columns bytes with one
// write port and a combinational peek port. Assumes NUM_BANKS is a power of 2.
module sdwb_array #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    parameter int ROW_W     = 2,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    input  logic [ROW_W-1:0]  wrow,
    input  logic [COL_W-1:0]  wcol,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BANK_W-1:0] rbank,
    input  logic [ROW_W-1:0]  rrow,
    input  logic [COL_W-1:0]  rcol,
    output logic [DATA_W-1:0] rdata
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;

    assign waddr = {wbank, wrow, wcol};
    assign raddr = {rbank, rrow, rcol};
    assign rdata = mem[raddr];

    // Clear on reset, otherwise store the strobed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/sdwb_top.sv
// sdwb_top: write burst engine of a two-bank synchronous DRAM model. Takes
// one decoded command per clock, stores four-beat write bursts and honours
// precharge cut-off. Assumes no ACTIVE to the bank of a running burst.
module sdwb_top
    import sdwb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 2,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cmd_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [ROW_W-1:0]     row_i,
    input  logic [COL_W-1:0]     col_i,
    input  logic [DATA_W-1:0]    din_i,
    input  logic                 dqm_i,
    input  logic                 cas_lat3_i,
    input  logic [BANK_W-1:0]    rd_bank_i,
    input  logic [ROW_W-1:0]     rd_row_i,
    input  logic [COL_W-1:0]     rd_col_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_BANKS-1:0] bank_open_o,
    output logic                 burst_busy_o,
    output logic                 err_o,
    output logic                 rec_viol_o
);
    cmd_e                          cmd;
    logic [NUM_BANKS-1:0][ROW_W-1:0] row_tab;
    logic [BANK_W-1:0]             burst_bank;
    logic [BEAT_W-1:0]             beat_idx;
    logic                          wr_en;
    logic [BANK_W-1:0]             wr_bank;
    logic [COL_W-1:0]              wr_col;
    logic                          last_beat;
    logic                          unused_cas;

    assign cmd        = cmd_e'(cmd_i);
    assign unused_cas = cas_lat3_i;

    sdwb_bank_track #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (cmd == CMD_ACT),
        .pre_en   (cmd == CMD_PRE),
        .bank     (bank_i),
        .row      (row_i),
        .open_o   (bank_open_o),
        .row_tab_o(row_tab)
    );

    sdwb_burst_ctrl #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .COL_W(COL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .bank        (bank_i),
        .col         (col_i),
        .dqm         (dqm_i),
        .bank_open   (bank_open_o),
        .busy_o      (burst_busy_o),
        .burst_bank_o(burst_bank),
        .beat_idx_o  (beat_idx),
        .wr_en_o     (wr_en),
        .wr_bank_o   (wr_bank),
        .wr_col_o    (wr_col),
        .last_beat_o (last_beat),
        .err_o       (err_o)
    );

    sdwb_recovery #(.BANK_W(BANK_W)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_beat (last_beat),
        .burst_bank(burst_bank),
        .cmd       (cmd),
        .bank      (bank_i),
        .viol_o    (rec_viol_o)
    );

    sdwb_array #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .DATA_W(DATA_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .wbank(wr_bank),
        .wrow (row_tab[wr_bank]),
        .wcol (wr_col),
        .wdata(din_i),
        .rbank(rd_bank_i),
        .rrow (rd_row_i),
        .rcol (rd_col_i),
        .rdata(rd_data_o)
    );
endmodule

// File: rtl/sdwb_chk.sv
// sdwb_chk: protocol properties of sdwb_top, attached by bind.
// Assumes no ACTIVE is issued to the bank of a running burst.
module sdwb_chk
    import sdwb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cmd_i,
    input logic [BANK_W-1:0]    bank_i,
    input logic [NUM_BANKS-1:0] bank_open_o,
    input logic                 burst_busy_o,
    input logic                 err_o,
    input logic                 rec_viol_o,
    input logic [BANK_W-1:0]    burst_bank,
    input logic [BEAT_W-1:0]    beat_idx
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);

    // R1
    wr_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WR && bank_open_o[bank_i]) |=> burst_busy_o);

    // R1
    burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy_o && beat_idx == LAST_IDX && cmd_i == CMD_NOP) |=> !burst_busy_o);

    // R3
    same_bank_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy_o && cmd_i == CMD_PRE && bank_i == burst_bank)
        |=> (!burst_busy_o && !bank_open_o[$past(bank_i)]));

    // R4
    other_bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy_o && cmd_i == CMD_PRE && bank_i != burst_bank && beat_idx != LAST_IDX)
        |=> burst_busy_o);

    // R6
    closed_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WR && !bank_open_o[bank_i]) |=> err_o);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R8
    viol_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_viol_o |-> ($past(cmd_i) == CMD_PRE));

    // R8
    viol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_viol_o |=> !rec_viol_o);
endmodule

bind sdwb_top sdwb_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .bank_open_o (bank_open_o),
    .burst_busy_o(burst_busy_o),
    .err_o       (err_o),
    .rec_viol_o  (rec_viol_o),
    .burst_bank  (burst_bank),
    .beat_idx    (beat_idx)
);

// File: tb/sim_sdwb_top.sv
`timescale 1ns/1ps
module sim_sdwb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_i = 2'd0;
    logic       bank_i = 1'b0;
    logic [1:0] row_i = 2'd0;
    logic [3:0] col_i = 4'd0;
    logic [7:0] din_i = 8'd0;
    logic       dqm_i = 1'b0;
    logic       cas_lat3_i = 1'b0;
    logic       rd_bank_i = 1'b0;
    logic [1:0] rd_row_i = 2'd0;
    logic [3:0] rd_col_i = 4'd0;
    logic [7:0] rd_data_o;
    logic [1:0] bank_open_o;
    logic       burst_busy_o, err_o, rec_viol_o;

    sdwb_top u0 (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    int m_mem [2][4][16];
    int m_open [2];
    int m_row [2];
    int m_busy, m_idx, m_base, m_bank, m_err, m_pend, m_pbank, m_rv;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        foreach (m_mem[b, r, c]) m_mem[b][r][c] = 0;
        m_open = '{0, 0}; m_row = '{0, 0};
        m_busy = 0; m_idx = 0; m_base = 0; m_bank = 0;
        m_err = 0; m_pend = 0; m_pbank = 0; m_rv = 0;
    endtask

    task automatic sweep(input string tag);
        int mism = 0;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 16; c++) begin
                    rd_bank_i = b[0]; rd_row_i = r[1:0]; rd_col_i = c[3:0];
                    #0.01;
                    if (int'(rd_data_o) != m_mem[b][r][c]) mism++;
                end
        chk(tag, mism, 0);
    endtask

    task automatic compare_all();
        chk("R1 busy", int'(burst_busy_o), m_busy);
        chk("R6/R7 err", int'(err_o), m_err);
        chk("R8 rec_viol", int'(rec_viol_o), m_rv);
        chk("R3/R4 bank_open", int'(bank_open_o), m_open[0] + 2 * m_open[1]);
        sweep("R1/R2/R3 array");
    endtask

    task automatic peek(input string tag, input int b, input int r, input int c, input int exp);
        rd_bank_i = b[0]; rd_row_i = r[1:0]; rd_col_i = c[3:0];
        #0.01;
        chk(tag, int'(rd_data_o), exp);
    endtask

    // one clock: drive, predict, advance, compare
    task automatic step(input int c, input int b, input int r, input int col,
                        input int d, input bit m);
        int n_busy, n_idx, n_base, n_bank, n_err, n_pend, n_pbank, n_rv;
        bit wr_ok, same, cont, last;
        int wb, wc;
        @(negedge clk);
        cmd_i = c[1:0]; bank_i = b[0]; row_i = r[1:0]; col_i = col[3:0];
        din_i = d[7:0]; dqm_i = m;
        n_busy = m_busy; n_idx = m_idx; n_base = m_base; n_bank = m_bank;
        n_err = m_err; last = 0; wb = -1; wc = 0;
        wr_ok = (c == 2) && (m_open[b] != 0);
        same  = (m_busy != 0) && (c == 3) && (b == m_bank);
        cont  = (m_busy != 0) && !same && !wr_ok;
        if (wr_ok) begin
            wb = b; wc = col;
            n_busy = 1; n_idx = 1; n_base = col; n_bank = b;
        end else if (cont) begin
            wb = m_bank; wc = (m_base / 4) * 4 + ((m_base + m_idx) % 4);
            n_idx = m_idx + 1;
            if (n_idx == 4) begin n_busy = 0; n_idx = 0; last = 1; end
        end else if (same) begin
            n_busy = 0; n_idx = 0;
        end
        if (c == 2 && (m_open[b] == 0 || m_busy != 0)) n_err = 1;
        n_rv = (m_pend != 0 && c == 3 && b == m_pbank) ? 1 : 0;
        n_pend = last ? 1 : 0; n_pbank = m_bank;
        @(posedge clk);
        #1;
        if (wb >= 0 && !m) m_mem[wb][m_row[wb]][wc] = d % 256;
        if (c == 1) begin m_open[b] = 1; m_row[b] = r; end
        if (c == 3) m_open[b] = 0;
        m_busy = n_busy; m_idx = n_idx; m_base = n_base; m_bank = n_bank;
        m_err = n_err; m_pend = n_pend; m_pbank = n_pbank; m_rv = n_rv;
        compare_all();
    endtask

    task automatic nop(); step(0, 0, 0, 0, 0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cmd_i = 2'd0; dqm_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_clear();
        #1;
        compare_all();   // R9
    endtask

    task automatic scenario_basic(input int tag_base);
        // R1: four beats at consecutive columns, bank 0 row 1
        step(1, 0, 1, 0, 0, 0);
        step(2, 0, 0, 4, tag_base + 1, 0);
        step(0, 0, 0, 0, tag_base + 2, 0);
        step(0, 0, 0, 0, tag_base + 3, 0);
        step(0, 0, 0, 0, tag_base + 4, 0);
        nop();
        peek("R1 beat0", 0, 1, 4, tag_base + 1);
        peek("R1 beat3", 0, 1, 7, tag_base + 4);
        // R3: same-bank PRECHARGE on beat 2 with dqm high drops beats 2 and 3
        step(2, 0, 0, 12, tag_base + 5, 0);
        step(0, 0, 0, 0, tag_base + 6, 0);
        step(3, 0, 0, 0, tag_base + 7, 1);
        chk("R3 busy cleared", int'(burst_busy_o), 0);
        step(0, 0, 0, 0, tag_base + 8, 0);
        peek("R3 cut beat", 0, 1, 14, 0);
        peek("R3 after cut", 0, 1, 15, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        chk("R9 reset busy", int'(burst_busy_o), 0);
        chk("R9 reset open", int'(bank_open_o), 0);

        scenario_basic(16);

        // R1 wrap inside the aligned group: start at column 6
        step(1, 0, 2, 0, 0, 0);
        step(2, 0, 0, 6, 33, 0);
        step(0, 0, 0, 0, 34, 0);
        step(0, 0, 0, 0, 35, 0);
        step(0, 0, 0, 0, 36, 0);
        peek("R1 wrap", 0, 2, 5, 36);

        // R2: masked beat 1 leaves column 9 empty, beat 2 still lands on 10
        step(2, 0, 0, 8, 41, 0);
        step(0, 0, 0, 0, 42, 1);
        step(0, 0, 0, 0, 43, 0);
        step(0, 0, 0, 0, 44, 0);
        peek("R2 masked", 0, 2, 9, 0);
        peek("R2 advanced", 0, 2, 10, 43);

        // R3 with dqm low: the byte on the PRECHARGE clock is still dropped
        step(2, 0, 0, 0, 51, 0);
        step(3, 0, 0, 0, 52, 0);
        peek("R3 zero delay", 0, 2, 1, 0);

        // R4: other-bank PRECHARGE during the burst
        step(1, 1, 3, 0, 0, 0);
        step(1, 0, 3, 0, 0, 0);
        step(2, 0, 0, 0, 61, 0);
        step(3, 1, 0, 0, 62, 0);
        chk("R4 still busy", int'(burst_busy_o), 1);
        step(0, 0, 0, 0, 63, 0);
        step(0, 0, 0, 0, 64, 0);
        peek("R4 beat1 kept", 0, 3, 1, 62);
        chk("R4 other closed", int'(bank_open_o[1]), 0);

        // R8: PRECHARGE right after last beat, then one clock later
        step(3, 0, 0, 0, 0, 0);
        chk("R8 pulse", int'(rec_viol_o), 1);
        nop();
        chk("R8 pulse width", int'(rec_viol_o), 0);
        peek("R8 beats kept", 0, 3, 3, 64);
        step(1, 0, 3, 0, 0, 0);
        step(2, 0, 0, 4, 71, 0);
        nop(); nop(); nop(); nop();
        step(3, 0, 0, 0, 0, 0);
        chk("R8 no pulse late", int'(rec_viol_o), 0);

        // R6: WRITE to closed bank 1
        chk("R6 err before", int'(err_o), 0);
        step(2, 1, 0, 0, 81, 0);
        chk("R6 err set", int'(err_o), 1);
        chk("R6 no burst", int'(burst_busy_o), 0);
        nop(); nop();
        chk("R6 sticky", int'(err_o), 1);

        // R7: restart mid-burst
        do_reset();
        step(1, 0, 0, 0, 0, 0);
        step(2, 0, 0, 0, 91, 0);
        step(0, 0, 0, 0, 92, 0);
        step(2, 0, 0, 8, 93, 0);
        chk("R7 err", int'(err_o), 1);
        step(0, 0, 0, 0, 94, 0);
        step(0, 0, 0, 0, 95, 0);
        step(0, 0, 0, 0, 96, 0);
        peek("R7 old stops", 0, 0, 2, 0);
        peek("R7 new last", 0, 0, 11, 96);

        // R5: same sequence with CAS latency 3 selected
        do_reset();
        cas_lat3_i = 1'b1;
        scenario_basic(16);
        cas_lat3_i = 1'b0;

        // mixed pseudo-random traffic against the model
        do_reset();
        step(1, 0, 1, 0, 0, 0);
        step(1, 1, 2, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom % 8);
            int b = int'($urandom % 2);
            c = (c < 3) ? 2 : (c < 5) ? 0 : (c < 6) ? 3 : 1;
            if (c == 1 && m_busy != 0 && b == m_bank) c = 0;
            cas_lat3_i = 1'($urandom % 2);
            step(c, b, int'($urandom % 4), int'($urandom % 16),
                 int'($urandom % 256), ($urandom % 4) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule